// File: doc/BRIEF.md
# Location-Addressed Packet Access Engine

This block sits between a host byte channel and a word-addressed local memory. It parses big-endian command packets that name a resource by a 24-bit location number. It performs byte-granular reads and writes inside that resource and returns acknowledge packets on an outgoing byte stream. After every response it raises a one-cycle doorbell so that the host knows a packet is waiting.

The engine accepts no command until the host has sent a four-byte startup word. From then on it decodes read, write, host-side acknowledge and shutdown packets. The base address and byte size of each resource come from a built-in table that is computed from parameters. Every transfer is clamped to the end of its resource. Long reads are split into several responses of bounded length. Writes that cover only part of a 32-bit word update it by read-modify-write, so the other bytes of that word are kept.

Top module: `lpe_engine`

## Requirements
- R1: After reset the engine discards input bytes until the last four bytes accepted form 0x10FFAA55 (first byte most significant). Bytes before that cause no response and no memory access.
- R2: The command byte selects the operation: 1 is a read request, 3 is a write request, 2 is a host read acknowledge, 4 is a host write acknowledge and 17 is shutdown. Requests carry a 3-byte location, a 4-byte offset and a 4-byte size, each most significant byte first.
- R3: The number of bytes transferred is the requested size, clamped so that offset plus count never exceeds the resource size. The count is 0 when the offset is at or beyond the resource size.
- R4: A read is answered with byte 2, the 3-byte location, a 4-byte length and that many payload bytes. A transfer longer than CHUNK_MAX (990) bytes is sent as successive responses of at most CHUNK_MAX bytes each.
- R5: Byte address = resource base + offset. The byte at address a occupies memory word a/4, bits [31-8*(a mod 4) -: 8]. A write updates only the addressed bytes, by read-modify-write of each enclosing word.
- R6: A write is answered with byte 4, the 3-byte location and a 4-byte field holding the number of bytes stored. The engine always consumes the full requested size of payload bytes and stores only the clamped count.
- R7: Every response is followed by a doorbell pulse exactly one cycle long, in the cycle after the last response byte is accepted.
- R8: A read of location 0, of a location at or above LOC_LIMIT, or with a clamped count of 0, returns a single response with length 0.
- R9: A write to location 0 is answered with field 0xFFFFFFFE. A write to a location at or above LOC_LIMIT is answered with 0xFFFFFFFD. Neither writes memory.
- R10: Unknown command bytes are dropped. A host write acknowledge consumes 7 further bytes. A host read acknowledge consumes 7 bytes plus the number of payload bytes in its size field. None of these produces output.
- R11: Shutdown (17) consumes three more bytes. After that the engine holds in_ready low and produces no output until reset.
- R12: While out_valid is high and out_ready is low, out_valid and out_data hold their values.
- R13: Resource n has base n*REGION_BYTES and size REGION_BYTES >> (n mod 4) bytes.
- R14: In reset, out_valid, doorbell, mem_rd_en and mem_wr_en are low. After reset, in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Host byte present |
| in_data | input | 8 | Host byte |
| in_ready | output | 1 | Engine accepts the host byte this cycle |
| out_valid | output | 1 | Response byte present |
| out_data | output | 8 | Response byte |
| out_ready | input | 1 | Host accepts the response byte |
| doorbell | output | 1 | One-cycle pulse after each response |
| mem_rd_en | output | 1 | Memory word read; data is returned the next cycle |
| mem_wr_en | output | 1 | Memory word write |
| mem_addr | output | ADDR_W-2 | Word address |
| mem_wdata | output | 32 | Write word |
| mem_rdata | input | 32 | Read word, valid the cycle after mem_rd_en |

## Verification
The properties assume that the memory returns read data exactly one cycle after mem_rd_en. They also assume that the host never sends a response stream shorter than the length it announces. The bench's memory model answers with that fixed latency, and every packet the stimulus sends is complete. The stimulus stalls out_ready in a repeating pattern during long reads, so that the hold property is exercised. The startup, shutdown and drop properties depend only on states that the stimulus reaches through complete packets.

// File: rtl/lpe_pkg.sv
package lpe_pkg;

    localparam logic [31:0] SYNC_WORD = 32'h10FF_AA55;

    localparam logic [7:0] OP_READ      = 8'd1;
    localparam logic [7:0] OP_READ_ACK  = 8'd2;
    localparam logic [7:0] OP_WRITE     = 8'd3;
    localparam logic [7:0] OP_WRITE_ACK = 8'd4;
    localparam logic [7:0] OP_BYE       = 8'd17;

    localparam logic [31:0] ACK_NULL_LOC  = 32'hFFFF_FFFE;
    localparam logic [31:0] ACK_RANGE_LOC = 32'hFFFF_FFFD;

    // request fields in arrival order
    typedef struct packed {
        logic [23:0] loc;
        logic [31:0] off;
        logic [31:0] size;
    } req_t;

    // response header in transmit order
    typedef struct packed {
        logic [7:0]  code;
        logic [23:0] loc;
        logic [31:0] field;
    } rsp_hdr_t;

    typedef enum logic [4:0] {
        S_SYNC, S_CMD, S_FIELDS, S_EVAL,
        S_RD_CHUNK, S_RD_FETCH, S_RD_LATCH, S_RD_PAY,
        S_TX_WAIT,
        S_WR_PAY, S_WR_FETCH, S_WR_LATCH, S_WR_FLUSH, S_WR_ACK,
        S_DRAIN, S_BYE, S_HALT
    } eng_state_e;

    typedef enum logic [1:0] {F_IDLE, F_HDR, F_PAY, F_BELL} frm_state_e;

    // big-endian lane select: lane 0 is the most significant byte
    function automatic logic [7:0] lane_get(logic [31:0] w, logic [1:0] lane);
        int sh;
        sh = 8 * (3 - int'(lane));
        return w[sh +: 8];
    endfunction

    function automatic logic [31:0] lane_put(logic [31:0] w, logic [1:0] lane,
                                             logic [7:0] b);
        logic [31:0] r;
        int sh;
        r  = w;
        sh = 8 * (3 - int'(lane));
        r[sh +: 8] = b;
        return r;
    endfunction

endpackage

// File: rtl/lpe_sync_detect.sv
module lpe_sync_detect
    import lpe_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       hit
);
    logic [23:0] hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else if (en && in_valid) begin
            hist_q <= {hist_q[15:0], in_data};
        end
    end

    assign hit = en && in_valid && ({hist_q, in_data} == SYNC_WORD);
endmodule

// File: rtl/lpe_loc_table.sv
module lpe_loc_table #(
    parameter int ADDR_W        = 20,
    parameter int LOC_LIMIT     = 100,
    parameter int REGION_BYTES  = 2048,
    parameter bit SHRINK_BY_LOC = 1'b1
) (
    input  logic [23:0]       loc,
    output logic [ADDR_W-1:0] base,
    output logic [31:0]       size,
    output logic              is_null,
    output logic              out_of_range
);
    localparam logic [31:0] REGION_W = 32'(REGION_BYTES);

    assign base         = ADDR_W'(loc) * ADDR_W'(REGION_BYTES);
    assign is_null      = (loc == 24'd0);
    assign out_of_range = (32'(loc) >= 32'(LOC_LIMIT));

    generate
        if (SHRINK_BY_LOC) begin : g_shrink
            assign size = REGION_W >> loc[1:0];
        end else begin : g_flat
            assign size = REGION_W;
        end
    endgenerate
endmodule

// File: rtl/lpe_rsp_framer.sv
module lpe_rsp_framer
    import lpe_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  rsp_hdr_t    hdr_in,
    input  logic [31:0] pay_cnt,
    input  logic        pay_valid,
    input  logic [7:0]  pay_data,
    output logic        pay_ready,
    output logic        out_valid,
    output logic [7:0]  out_data,
    input  logic        out_ready,
    output logic        doorbell,
    output logic        busy
);
    frm_state_e  f_q;
    logic [2:0]  idx_q;
    logic [31:0] left_q;
    rsp_hdr_t    hdr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            f_q    <= F_IDLE;
            idx_q  <= '0;
            left_q <= '0;
            hdr_q  <= '0;
        end else begin
            case (f_q)
                F_IDLE: if (start) begin
                    hdr_q  <= hdr_in;
                    left_q <= pay_cnt;
                    idx_q  <= '0;
                    f_q    <= F_HDR;
                end
                F_HDR: if (out_ready) begin
                    idx_q <= idx_q + 3'd1;
                    if (idx_q == 3'd7) f_q <= (left_q == '0) ? F_BELL : F_PAY;
                end
                F_PAY: if (out_ready && pay_valid) begin
                    left_q <= left_q - 32'd1;
                    if (left_q == 32'd1) f_q <= F_BELL;
                end
                default: f_q <= F_IDLE;
            endcase
        end
    end

    always_comb begin
        out_valid = (f_q == F_HDR) || ((f_q == F_PAY) && pay_valid);
        out_data  = (f_q == F_HDR) ? hdr_q[8 * (7 - int'(idx_q)) +: 8] : pay_data;
        pay_ready = (f_q == F_PAY) && out_ready;
        doorbell  = (f_q == F_BELL);
        busy      = (f_q != F_IDLE);
    end
endmodule

// File: rtl/lpe_engine.sv
module lpe_engine
    import lpe_pkg::*;
#(
    parameter int ADDR_W       = 20,
    parameter int LOC_LIMIT    = 100,
    parameter int REGION_BYTES = 2048,
    parameter int CHUNK_MAX    = 990
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [7:0]        out_data,
    input  logic              out_ready,
    output logic              doorbell,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [ADDR_W-3:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata
);
    localparam int          WORD_AW = ADDR_W - 2;
    localparam logic [31:0] CHUNK_W = 32'(CHUNK_MAX);

    eng_state_e        state_q, state_d;
    logic [7:0]        op_q, op_d;
    logic [3:0]        cnt_q, cnt_d;
    req_t              req_q, req_d;
    logic [31:0]       n_q, n_d;          // bytes still to store or read
    logic [31:0]       take_q, take_d;    // payload bytes still to consume
    logic [31:0]       chunk_q, chunk_d;  // bytes left in the current response
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic [31:0]       word_q, word_d;
    logic              word_ok_q, word_ok_d;
    logic [31:0]       ackf_q, ackf_d;

    logic              sync_hit;
    logic [ADDR_W-1:0] tbl_base;
    logic [31:0]       tbl_size;
    logic              tbl_null, tbl_range;
    logic [31:0]       room, clamped, chunk_now;
    logic              take_byte;

    logic              tx_start, tx_busy, tx_pay_valid, tx_pay_ready;
    rsp_hdr_t          tx_hdr;
    logic [31:0]       tx_pay_cnt;
    logic [7:0]        tx_pay_data;

    logic              sync_phase, halt_phase;

    lpe_sync_detect u_sync (
        .clk      (clk),
        .rst      (rst),
        .en       (state_q == S_SYNC),
        .in_valid (in_valid),
        .in_data  (in_data),
        .hit      (sync_hit)
    );

    lpe_loc_table #(
        .ADDR_W        (ADDR_W),
        .LOC_LIMIT     (LOC_LIMIT),
        .REGION_BYTES  (REGION_BYTES),
        .SHRINK_BY_LOC (1'b1)
    ) u_table (
        .loc          (req_q.loc),
        .base         (tbl_base),
        .size         (tbl_size),
        .is_null      (tbl_null),
        .out_of_range (tbl_range)
    );

    lpe_rsp_framer u_framer (
        .clk       (clk),
        .rst       (rst),
        .start     (tx_start),
        .hdr_in    (tx_hdr),
        .pay_cnt   (tx_pay_cnt),
        .pay_valid (tx_pay_valid),
        .pay_data  (tx_pay_data),
        .pay_ready (tx_pay_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_ready (out_ready),
        .doorbell  (doorbell),
        .busy      (tx_busy)
    );

    // clamp against the selected resource
    always_comb begin
        room    = tbl_size - req_q.off;
        clamped = (req_q.off >= tbl_size) ? 32'd0 :
                  ((req_q.size > room) ? room : req_q.size);
        chunk_now = (n_q > CHUNK_W) ? CHUNK_W : n_q;
    end

    assign mem_addr   = addr_q[ADDR_W-1:2];
    assign sync_phase = (state_q == S_SYNC);
    assign halt_phase = (state_q == S_HALT);

    always_comb begin
        case (state_q)
            S_SYNC, S_CMD, S_FIELDS, S_DRAIN, S_BYE: in_ready = 1'b1;
            S_WR_PAY: in_ready = (take_q != '0) && !((n_q != '0) && !word_ok_q);
            default:  in_ready = 1'b0;
        endcase
    end
    assign take_byte = in_ready && in_valid;

    always_comb begin
        state_d   = state_q;
        op_d      = op_q;
        cnt_d     = cnt_q;
        req_d     = req_q;
        n_d       = n_q;
        take_d    = take_q;
        chunk_d   = chunk_q;
        addr_d    = addr_q;
        word_d    = word_q;
        word_ok_d = word_ok_q;
        ackf_d    = ackf_q;

        mem_rd_en    = 1'b0;
        mem_wr_en    = 1'b0;
        mem_wdata    = word_q;
        tx_start     = 1'b0;
        tx_hdr       = '0;
        tx_pay_cnt   = '0;
        tx_pay_valid = 1'b0;
        tx_pay_data  = lane_get(word_q, addr_q[1:0]);

        case (state_q)
            S_SYNC: if (sync_hit) state_d = S_CMD;

            S_CMD: if (take_byte) begin
                op_d = in_data;
                case (in_data)
                    OP_READ, OP_WRITE: begin
                        cnt_d   = 4'd10;
                        state_d = S_FIELDS;
                    end
                    OP_READ_ACK, OP_WRITE_ACK: begin
                        cnt_d   = 4'd6;
                        state_d = S_FIELDS;
                    end
                    OP_BYE: begin
                        cnt_d   = 4'd2;
                        state_d = S_BYE;
                    end
                    default: state_d = S_CMD;
                endcase
            end

            S_FIELDS: if (take_byte) begin
                req_d = req_t'({req_q[79:0], in_data});
                cnt_d = cnt_q - 4'd1;
                if (cnt_q == 4'd0) state_d = S_EVAL;
            end

            S_EVAL: begin
                addr_d    = tbl_base + ADDR_W'(req_q.off);
                word_ok_d = 1'b0;
                case (op_q)
                    OP_READ: begin
                        n_d     = (tbl_null || tbl_range) ? 32'd0 : clamped;
                        state_d = S_RD_CHUNK;
                    end
                    OP_WRITE: begin
                        take_d  = req_q.size;
                        n_d     = (tbl_null || tbl_range) ? 32'd0 : clamped;
                        ackf_d  = tbl_null  ? ACK_NULL_LOC  :
                                  tbl_range ? ACK_RANGE_LOC : clamped;
                        state_d = S_WR_PAY;
                    end
                    OP_READ_ACK: begin
                        take_d  = req_q.size;
                        state_d = (req_q.size == '0) ? S_CMD : S_DRAIN;
                    end
                    default: state_d = S_CMD;
                endcase
            end

            S_RD_CHUNK: begin
                tx_start   = 1'b1;
                tx_hdr     = '{code: OP_READ_ACK, loc: req_q.loc, field: chunk_now};
                tx_pay_cnt = chunk_now;
                chunk_d    = chunk_now;
                n_d        = n_q - chunk_now;
                if (chunk_now == '0)  state_d = S_TX_WAIT;
                else if (word_ok_q)   state_d = S_RD_PAY;
                else                  state_d = S_RD_FETCH;
            end

            S_RD_FETCH: begin
                mem_rd_en = 1'b1;
                state_d   = S_RD_LATCH;
            end

            S_RD_LATCH: begin
                word_d    = mem_rdata;
                word_ok_d = 1'b1;
                state_d   = S_RD_PAY;
            end

            S_RD_PAY: begin
                tx_pay_valid = 1'b1;
                if (tx_pay_ready) begin
                    addr_d  = addr_q + ADDR_W'(1);
                    chunk_d = chunk_q - 32'd1;
                    if (addr_q[1:0] == 2'd3) word_ok_d = 1'b0;
                    if (chunk_q == 32'd1)          state_d = S_TX_WAIT;
                    else if (addr_q[1:0] == 2'd3)  state_d = S_RD_FETCH;
                end
            end

            S_TX_WAIT: if (!tx_busy) begin
                state_d = ((op_q == OP_READ) && (n_q != '0)) ? S_RD_CHUNK : S_CMD;
            end

            S_WR_PAY: begin
                if (take_q == '0) begin
                    state_d = S_WR_FLUSH;
                end else if ((n_q != '0) && !word_ok_q) begin
                    state_d = S_WR_FETCH;
                end else if (in_valid) begin
                    take_d = take_q - 32'd1;
                    if (n_q != '0) begin
                        word_d = lane_put(word_q, addr_q[1:0], in_data);
                        n_d    = n_q - 32'd1;
                        addr_d = addr_q + ADDR_W'(1);
                        if (addr_q[1:0] == 2'd3) begin
                            mem_wr_en = 1'b1;
                            mem_wdata = lane_put(word_q, 2'd3, in_data);
                            word_ok_d = 1'b0;
                        end
                    end
                end
            end

            S_WR_FETCH: begin
                mem_rd_en = 1'b1;
                state_d   = S_WR_LATCH;
            end

            S_WR_LATCH: begin
                word_d    = mem_rdata;
                word_ok_d = 1'b1;
                state_d   = S_WR_PAY;
            end

            S_WR_FLUSH: begin
                if (word_ok_q) begin
                    mem_wr_en = 1'b1;
                    mem_wdata = word_q;
                end
                word_ok_d = 1'b0;
                state_d   = S_WR_ACK;
            end

            S_WR_ACK: begin
                tx_start = 1'b1;
                tx_hdr   = '{code: OP_WRITE_ACK, loc: req_q.loc, field: ackf_q};
                state_d  = S_TX_WAIT;
            end

            S_DRAIN: if (take_byte) begin
                take_d = take_q - 32'd1;
                if (take_q == 32'd1) state_d = S_CMD;
            end

            S_BYE: if (take_byte) begin
                cnt_d = cnt_q - 4'd1;
                if (cnt_q == 4'd0) state_d = S_HALT;
            end

            S_HALT: state_d = S_HALT;

            default: state_d = S_SYNC;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= S_SYNC;
            op_q      <= '0;
            cnt_q     <= '0;
            req_q     <= '0;
            n_q       <= '0;
            take_q    <= '0;
            chunk_q   <= '0;
            addr_q    <= '0;
            word_q    <= '0;
            word_ok_q <= 1'b0;
            ackf_q    <= '0;
        end else begin
            state_q   <= state_d;
            op_q      <= op_d;
            cnt_q     <= cnt_d;
            req_q     <= req_d;
            n_q       <= n_d;
            take_q    <= take_d;
            chunk_q   <= chunk_d;
            addr_q    <= addr_d;
            word_q    <= word_d;
            word_ok_q <= word_ok_d;
            ackf_q    <= ackf_d;
        end
    end

    if (WORD_AW < 1) begin : g_bad_width
        initial $error("ADDR_W too small");
    end
endmodule

// File: rtl/lpe_engine_checker.sv
module lpe_engine_checker (
    input logic       clk,
    input logic       rst,
    input logic       in_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       doorbell,
    input logic       mem_rd_en,
    input logic       mem_wr_en,
    input logic       in_sync,
    input logic       halted
);
    // R1: nothing leaves the block before the startup word
    a_r1_quiet_before_sync: assert property (@(posedge clk) disable iff (rst)
        in_sync |-> (!out_valid && !mem_rd_en && !mem_wr_en));

    // R7: doorbell is a single-cycle pulse
    a_r7_bell_single: assert property (@(posedge clk) disable iff (rst)
        doorbell |=> !doorbell);

    // R7: doorbell directly follows an accepted response byte
    a_r7_bell_after_byte: assert property (@(posedge clk) disable iff (rst)
        doorbell |-> $past(out_valid && out_ready));

    // R12: a stalled response byte is held
    a_r12_out_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R11: shutdown is final until reset
    a_r11_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && !in_ready && !out_valid));

    // R5: one memory operation per cycle
    a_r5_mem_single_op: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_en && mem_wr_en));
endmodule

bind lpe_engine lpe_engine_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .doorbell  (doorbell),
    .mem_rd_en (mem_rd_en),
    .mem_wr_en (mem_wr_en),
    .in_sync   (sync_phase),
    .halted    (halt_phase)
);

// File: tb/lpe_engine_test.sv
module lpe_engine_test;
    localparam int ADDR_W = 20;
    localparam int REGION = 2048;
    localparam int LIMIT  = 100;
    localparam int CHUNK  = 990;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [7:0]        in_data = '0;
    logic              in_ready;
    logic              out_valid;
    logic [7:0]        out_data;
    logic              out_ready = 1'b1;
    logic              doorbell;
    logic              mem_rd_en, mem_wr_en;
    logic [ADDR_W-3:0] mem_addr;
    logic [31:0]       mem_wdata;
    logic [31:0]       mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_byte_cyc = -10;
    int wr_count = 0;
    int stall_mode = 0;
    bit done = 1'b0;
    string phase = "R1";

    int    exp_q[$];
    string tag_q[$];
    logic [31:0] mem_q[int];
    logic [31:0] shadow_q[int];

    always #5 clk = ~clk;

    lpe_engine #(.ADDR_W(ADDR_W), .LOC_LIMIT(LIMIT), .REGION_BYTES(REGION),
                 .CHUNK_MAX(CHUNK)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
        .out_ready(out_ready), .doorbell(doorbell), .mem_rd_en(mem_rd_en),
        .mem_wr_en(mem_wr_en), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata));

    function automatic logic [31:0] init_word(int w);
        return (w * 32'h0100_0193) ^ 32'hC3A5_5A3C;
    endfunction
    function automatic logic [31:0] mem_word(int w);
        return mem_q.exists(w) ? mem_q[w] : init_word(w);
    endfunction
    function automatic logic [31:0] shadow_word(int w);
        return shadow_q.exists(w) ? shadow_q[w] : init_word(w);
    endfunction
    function automatic logic [7:0] shadow_byte(int a);
        logic [31:0] w;
        w = shadow_word(a / 4);
        return w[8 * (3 - (a % 4)) +: 8];
    endfunction
    function automatic void shadow_set(int a, logic [7:0] b);
        logic [31:0] w;
        w = shadow_word(a / 4);
        w[8 * (3 - (a % 4)) +: 8] = b;
        shadow_q[a / 4] = w;
    endfunction

    // R13: resource table
    function automatic int res_size(int loc);
        return REGION >> (loc % 4);
    endfunction
    function automatic int res_base(int loc);
        return loc * REGION;
    endfunction
    // R3: clamp
    function automatic int clamp(int loc, int off, int size);
        if (loc == 0 || loc >= LIMIT) return 0;
        if (off >= res_size(loc)) return 0;
        return (off + size > res_size(loc)) ? res_size(loc) - off : size;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // memory model with one-cycle read latency
    always @(posedge clk) begin
        if (mem_wr_en) begin
            mem_q[int'(mem_addr)] = mem_wdata;
            wr_count++;
        end
        if (mem_rd_en) mem_rdata <= mem_word(int'(mem_addr));
    end

    // output monitor: compare every accepted byte and doorbell against the model
    always @(negedge clk) begin
        cyc++;
        out_ready = (stall_mode == 0) ? 1'b1 : ((cyc % 4) != 1);
        #1;
        if (!rst) begin
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, {phase, " unexpected byte"}, int'(out_data), -1);
                end else begin
                    int e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(int'(out_data) == e, t, int'(out_data), e);
                end
                last_byte_cyc = cyc;
            end
            if (doorbell) begin
                check(last_byte_cyc == cyc - 1, "R7 doorbell timing", cyc - last_byte_cyc, 1);
                if (exp_q.size() == 0) begin
                    check(1'b0, {phase, " unexpected doorbell"}, 256, -1);
                end else begin
                    int e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(e == 256, t, 256, e);
                end
            end
        end
    end

    task automatic expb(int b, string t);
        exp_q.push_back(b & 255);
        tag_q.push_back(t);
    endtask
    task automatic exp_hdr(int code, int loc, int f, string t);
        expb(code, t);
        expb(loc >> 16, t); expb(loc >> 8, t); expb(loc, t);
        expb(f >> 24, t); expb(f >> 16, t); expb(f >> 8, t); expb(f, t);
    endtask
    task automatic exp_bell();
        exp_q.push_back(256);
        tag_q.push_back("R7 doorbell");
    endtask

    task automatic put(int b);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 8'(b);
        #2;
        while (!in_ready) begin
            @(negedge clk);
            #2;
        end
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask
    task automatic put3(int v);
        put(v >> 16); put(v >> 8); put(v);
    endtask
    task automatic put4(int v);
        put(v >> 24); put(v >> 16); put(v >> 8); put(v);
    endtask

    task automatic settle();
        int t = 0;
        while (exp_q.size() != 0 && t < 20000) begin
            @(negedge clk);
            t++;
        end
        if (exp_q.size() != 0) begin
            check(1'b0, {tag_q[0], " missing output"}, 0, exp_q[0]);
            exp_q.delete();
            tag_q.delete();
        end
        repeat (20) @(negedge clk);
    endtask

    task automatic do_read(int loc, int off, int size, string t);
        int n, a;
        n = clamp(loc, off, size);
        a = res_base(loc) + off;
        do begin
            int c;
            c = (n > CHUNK) ? CHUNK : n;
            exp_hdr(2, loc, c, t);
            for (int i = 0; i < c; i++) begin
                expb(int'(shadow_byte(a)), t);
                a++;
            end
            exp_bell();
            n -= c;
        end while (n > 0);
        phase = t;
        put(1); put3(loc); put4(off); put4(size);
        settle();
    endtask

    task automatic do_write(int loc, int off, int size, int seed, string t);
        int n, f;
        n = clamp(loc, off, size);
        f = (loc == 0) ? 32'hFFFF_FFFE : (loc >= LIMIT) ? 32'hFFFF_FFFD : n;
        for (int i = 0; i < n; i++) shadow_set(res_base(loc) + off + i, 8'(seed + 7 * i));
        exp_hdr(4, loc, f, t);
        exp_bell();
        phase = t;
        put(3); put3(loc); put4(off); put4(size);
        for (int i = 0; i < size; i++) put(seed + 7 * i);
        settle();
    endtask

    task automatic mem_cmp(int w, string t);
        check(mem_word(w) == shadow_word(w), t, int'(mem_word(w)), int'(shadow_word(w)));
    endtask

    initial begin
        int w0;
        repeat (3) @(negedge clk);
        #2;
        // R14: reset state
        check(!out_valid, "R14 out_valid", int'(out_valid), 0);
        check(!doorbell, "R14 doorbell", int'(doorbell), 0);
        check(!mem_rd_en && !mem_wr_en, "R14 mem idle", int'({mem_rd_en, mem_wr_en}), 0);
        @(negedge clk);
        rst = 1'b0;
        #2;
        check(in_ready, "R14 in_ready after reset", int'(in_ready), 1);

        // R1: a write before the startup word is ignored
        phase = "R1 pre-sync";
        put(3); put3(1); put4(0); put4(1); put(8'hAB);
        put(8'h10); put(8'hFF); put(8'hAA); put(8'h10); put(8'hFF); put(8'hAA); put(8'h55);
        repeat (20) @(negedge clk);
        check(wr_count == 0, "R1 no memory write before sync", wr_count, 0);
        mem_cmp(512, "R1 memory untouched");

        // R2 R6 R13: aligned write then check placement
        do_write(1, 0, 8, 8'h11, "R6 write ack loc1");
        mem_cmp(512, "R13 base of loc1 word0");
        mem_cmp(513, "R13 base of loc1 word1");

        // R5: unaligned write preserves neighbouring bytes
        do_write(5, 1, 5, 8'h40, "R5 unaligned write ack");
        w0 = res_base(5) / 4;
        mem_cmp(w0, "R5 first word merge");
        mem_cmp(w0 + 1, "R5 second word merge");
        do_read(5, 0, 8, "R4 read loc5");

        // R3: clamped write consumes all bytes, next command still parsed
        do_write(3, 250, 10, 8'h90, "R3 clamped write ack");
        do_read(3, 248, 20, "R3 clamped read");

        // R9: refused writes
        w0 = wr_count;
        do_write(0, 0, 4, 8'h22, "R9 write loc0");
        do_write(LIMIT, 0, 2, 8'h33, "R9 write out of range");
        check(wr_count == w0, "R9 no memory write", wr_count - w0, 0);

        // R6: zero-size write
        do_write(1, 4, 0, 0, "R6 zero-size write ack");

        // R8: empty read responses
        do_read(0, 0, 4, "R8 read loc0");
        do_read(150, 0, 4, "R8 read out of range");
        do_read(2, 600, 4, "R8 read beyond size");

        // R4 R12: chunked read under back-pressure
        do_write(4, 3, 40, 8'h05, "R6 write loc4");
        stall_mode = 1;
        do_read(4, 3, 1000, "R4 chunked read");
        stall_mode = 0;

        // R10: dropped and drained packets
        phase = "R10 drop";
        put(9);
        put(2); put3(0); put4(3); put(3); put(3); put(1);
        put(4); put3(1); put4(0);
        repeat (20) @(negedge clk);
        do_read(1, 2, 5, "R10 read after drops");

        // R11: shutdown
        phase = "R11 halt";
        put(17); put(1); put(2); put(3);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            #2;
            check(!in_ready && !out_valid, "R11 halted", int'({in_ready, out_valid}), 0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule